// File: doc/BRIEF.md
# TLB Random Index Generator

This block chooses which translation-table slot to overwrite when a new mapping has to replace an old one. Every accepted request advances a 32-bit congruential state, takes the top sixteen bits of the new state and folds them into the span of entries that are not locked. The lowest slots, up to the wired count, are locked and are never returned. The table size is a parameter, and the result is as wide as the number of bits needed to address one entry.

The fold is a bit-serial restoring remainder: one quotient bit per clock, sixteen clocks per index. While that runs the block is busy, and request strobes are dropped. The wired count is captured when a request is accepted. If the wired count covers the whole table, no division takes place and the top slot comes back on the next cycle. A finished index is held on the output, and a valid strobe lasting a single cycle marks it.

Top module: `tlbrep_index_gen`

## Requirements
- R1: A synchronous reset clears the congruential state to zero, drives `valid_o` low and drives `idx_o` to zero.
- R2: Each accepted request replaces the state with (state × 314159 + 1) mod 2^32, exactly once.
- R3: With a captured wired count w below ENTRIES, the result equals ((new state >> 16) mod (ENTRIES − w)) + w.
- R4: Every index with w below ENTRIES lies between w and ENTRIES − 1, inclusive.
- R5: With w at or above ENTRIES (wired input is IDX_W+1 bits wide), the result is ENTRIES − 1, valid on the cycle after acceptance, and the state still advances.
- R6: In the normal case `valid_o` rises 16 clocks after the accepting edge and stays high for exactly one cycle.
- R7: A request raised while a reduction runs is ignored: it produces no extra valid pulse and no advance of the sequence.
- R8: `wired_i` is sampled only at acceptance; changing it during a reduction has no effect on the result.
- R9: A request held high is accepted again on the first edge after the valid cycle, so a constant strobe yields one index every 17 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request for a new replacement index |
| wired_i | input | IDX_W+1 | Count of locked low entries |
| idx_o | output | IDX_W | Last produced replacement index |
| valid_o | output | 1 | One-cycle strobe marking a new index |

## Verification
Requests with a wired count of zero test the raw congruential sequence and the full-range fold. Wired counts of 1, 5 and 15 test the offset and the shrinking divisor, down to a divisor of one. Counts of 16, 20 and 31 take the clamp path, which is the only path that answers after a single cycle. Three sequences test the request gate and the capture of the wired count, because any slip shifts every later index in the model: strobes pulsed during a reduction, the wired input changed during a reduction, and a request held high through two results.

// File: rtl/tlbrep_pkg.sv
package tlbrep_pkg;

  localparam logic [31:0] LCG_MUL = 32'd314159;
  localparam logic [31:0] LCG_INC = 32'd1;
  localparam int          FOLD_BITS = 16;

  typedef enum logic { GEN_IDLE = 1'b0, GEN_REDUCE = 1'b1 } gen_state_e;

  // one step of the congruential sequence, truncated to 32 bits
  function automatic logic [31:0] lcg_advance(input logic [31:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction

  // one restoring remainder step: shift in a bit, subtract if it fits
  function automatic logic [31:0] rem_step(input logic [31:0] r,
                                           input logic        b,
                                           input logic [31:0] d);
    logic [31:0] trial;
    trial = {r[30:0], b};
    return (trial >= d) ? (trial - d) : trial;
  endfunction

endpackage

// File: rtl/tlbrep_lcg.sv
module tlbrep_lcg
  import tlbrep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step_i,
  output logic [31:0] state_o,
  output logic [15:0] upper_next_o
);

  logic [31:0] state_q;
  logic [31:0] state_next;

  assign state_next   = lcg_advance(state_q);
  assign upper_next_o = state_next[31:16];
  assign state_o      = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (step_i) begin
      state_q <= state_next;
    end
  end

endmodule

// File: rtl/tlbrep_modred.sv
module tlbrep_modred
  import tlbrep_pkg::*;
#(
  parameter int DIVIDEND_W = 16,
  parameter int IDX_W      = 4,
  localparam int REM_W     = IDX_W + 2,
  localparam int CNT_W     = (DIVIDEND_W > 1) ? $clog2(DIVIDEND_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic [DIVIDEND_W-1:0] dividend_i,
  input  logic [REM_W-1:0]      divisor_i,
  output logic [IDX_W-1:0]      rem_o,
  output logic                  last_o,
  output logic                  active_o
);

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIVIDEND_W - 1);

  logic [DIVIDEND_W-1:0] dq_q;
  logic [REM_W-1:0]      r_q;
  logic [REM_W-1:0]      div_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  active_q;
  logic [REM_W-1:0]      r_next;

  assign r_next   = REM_W'(rem_step(32'(r_q), dq_q[DIVIDEND_W-1], 32'(div_q)));
  assign last_o   = active_q && (cnt_q == LAST_STEP);
  assign rem_o    = r_next[IDX_W-1:0];
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_q     <= '0;
      r_q      <= '0;
      div_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      dq_q     <= dividend_i;
      r_q      <= '0;
      div_q    <= divisor_i;
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      dq_q  <= dq_q << 1;
      r_q   <= r_next;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_STEP) begin
        active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlbrep_ctrl.sv
module tlbrep_ctrl
  import tlbrep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic clamp_i,
  input  logic last_i,
  output logic accept_o,
  output logic launch_o,
  output logic clamp_fire_o,
  output logic busy_o
);

  gen_state_e st_q;
  gen_state_e st_d;

  assign busy_o       = (st_q == GEN_REDUCE);
  assign accept_o     = req_i && !busy_o;
  assign launch_o     = accept_o && !clamp_i;
  assign clamp_fire_o = accept_o && clamp_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      GEN_IDLE:   if (launch_o) st_d = GEN_REDUCE;
      GEN_REDUCE: if (last_i)   st_d = GEN_IDLE;
      default:    st_d = GEN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= GEN_IDLE;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/tlbrep_index_gen.sv
module tlbrep_index_gen
  import tlbrep_pkg::*;
#(
  parameter int ENTRIES  = 16,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIRED_W = IDX_W + 1,
  localparam int REM_W   = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic [WIRED_W-1:0] wired_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

  // named internal events, visible to the bound checker
  logic              accept;
  logic              launch;
  logic              clamp_fire;
  logic              busy;
  logic              clamp_sel;
  logic              red_last;
  logic              red_active;
  logic [31:0]       lcg_state;
  logic [15:0]       upper_next;
  logic [REM_W-1:0]  divisor;
  logic [IDX_W-1:0]  red_rem;
  logic [IDX_W-1:0]  wired_q;
  logic              clamp_q;
  logic [IDX_W-1:0]  idx_q;
  logic              valid_q;

  assign clamp_sel = (wired_i >= WIRED_W'(ENTRIES));
  assign divisor   = REM_W'(ENTRIES) - REM_W'(wired_i);

  tlbrep_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .clamp_i      (clamp_sel),
    .last_i       (red_last),
    .accept_o     (accept),
    .launch_o     (launch),
    .clamp_fire_o (clamp_fire),
    .busy_o       (busy)
  );

  tlbrep_lcg u_lcg (
    .clk          (clk),
    .rst          (rst),
    .step_i       (accept),
    .state_o      (lcg_state),
    .upper_next_o (upper_next)
  );

  tlbrep_modred #(
    .DIVIDEND_W (FOLD_BITS),
    .IDX_W      (IDX_W)
  ) u_red (
    .clk        (clk),
    .rst        (rst),
    .load_i     (launch),
    .dividend_i (upper_next),
    .divisor_i  (divisor),
    .rem_o      (red_rem),
    .last_o     (red_last),
    .active_o   (red_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wired_q <= '0;
      clamp_q <= 1'b0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        wired_q <= wired_i[IDX_W-1:0];
        clamp_q <= clamp_sel;
      end
      if (clamp_fire) begin
        idx_q   <= TOP_IDX;
        valid_q <= 1'b1;
      end else if (red_last && red_active) begin
        idx_q   <= red_rem + wired_q;
        valid_q <= 1'b1;
      end
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/tlbrep_checker.sv
module tlbrep_checker #(
  parameter int ENTRIES  = 16,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIRED_W = IDX_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               req_i,
  input logic [WIRED_W-1:0] wired_i,
  input logic [IDX_W-1:0]   idx_o,
  input logic               valid_o,
  input logic               accept,
  input logic               busy,
  input logic [31:0]        lcg_state,
  input logic [IDX_W-1:0]   wired_q,
  input logic               clamp_q
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!valid_o && lcg_state == 32'd0 && idx_o == '0));

  assert_lcg_advance_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> lcg_state == 32'($past(lcg_state) * 32'd314159 + 32'd1));

  assert_index_range_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !clamp_q) |-> (idx_o >= wired_q));

  assert_clamp_top_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && wired_i >= WIRED_W'(ENTRIES)) |=> (valid_o && idx_o == IDX_W'(ENTRIES - 1)));

  assert_quiet_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !valid_o);

  assert_ignore_busy_req_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && req_i) |=> $stable(lcg_state));

  assert_wired_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> $stable(wired_q));

endmodule

bind tlbrep_index_gen tlbrep_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .wired_i   (wired_i),
  .idx_o     (idx_o),
  .valid_o   (valid_o),
  .accept    (accept),
  .busy      (busy),
  .lcg_state (lcg_state),
  .wired_q   (wired_q),
  .clamp_q   (clamp_q)
);

// File: tb/tlbrep_index_gen_test.sv
`timescale 1ns/1ps
module tlbrep_index_gen_test;

  localparam int N       = 16;
  localparam int IW      = 4;
  localparam int WW      = 5;
  localparam int FOLD_LAT = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_i = 1'b0;
  logic [WW-1:0] wired_i = '0;
  logic [IW-1:0] idx_o;
  logic          valid_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] m_seed = 32'd0;

  always #2 clk = ~clk;

  tlbrep_index_gen #(.ENTRIES(N)) uut (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .wired_i (wired_i),
    .idx_o   (idx_o),
    .valid_o (valid_o)
  );

  function automatic logic [31:0] model_next(input logic [31:0] s);
    logic [63:0] wide;
    wide = 64'(s) * 64'd314159 + 64'd1;
    return wide[31:0];
  endfunction

  function automatic int model_idx(input logic [31:0] s, input int w);
    int hi;
    if (w >= N) return N - 1;
    hi = int'(s >> 16);
    return (hi % (N - w)) + w;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // mode 0 plain, 1 pulse req while busy, 2 move wired while busy
  task automatic do_req(input int w, input int mode, input string rq);
    int n;
    int exp_idx;
    int exp_lat;
    bit seen;
    @(negedge clk);
    req_i   = 1'b1;
    wired_i = WW'(w);
    @(posedge clk);
    m_seed  = model_next(m_seed);
    exp_idx = model_idx(m_seed, w);
    exp_lat = (w >= N) ? 0 : FOLD_LAT;
    seen = 1'b0;
    n = 0;
    @(negedge clk);
    req_i = 1'b0;
    while (!seen && n < 40) begin
      if (valid_o) begin
        seen = 1'b1;
      end else begin
        if (mode == 1) req_i = (n >= 2 && n <= 9);
        if (mode == 2) wired_i = WW'((w + 6) % N);
        @(negedge clk);
        n++;
      end
    end
    req_i   = 1'b0;
    wired_i = WW'(w);
    chk(seen, {rq, " valid seen"}, int'(seen), 1);
    chk(n == exp_lat, {rq, " latency"}, n, exp_lat);
    chk(int'(idx_o) == exp_idx, {rq, " index"}, int'(idx_o), exp_idx);
    if (w < N) chk(int'(idx_o) >= w && int'(idx_o) <= N - 1, "R4 range", int'(idx_o), w);
    @(negedge clk);
    chk(!valid_o, "R6 one-cycle valid", int'(valid_o), 0);
  endtask

  task automatic t_reset();
    chk(!valid_o, "R1 valid low after reset", int'(valid_o), 0);
    chk(idx_o == '0, "R1 index zero after reset", int'(idx_o), 0);
    do_req(0, 0, "R1 first index from zero state");
  endtask

  task automatic t_seq_full();
    for (int i = 0; i < 6; i++) do_req(0, 0, "R2 R3 full range");
  endtask

  task automatic t_wired();
    for (int i = 0; i < 4; i++) do_req(1, 0, "R3 wired=1");
    for (int i = 0; i < 4; i++) do_req(5, 0, "R3 wired=5");
    for (int i = 0; i < 3; i++) do_req(15, 0, "R4 wired=15");
  endtask

  task automatic t_clamp();
    do_req(16, 0, "R5 wired=16");
    do_req(20, 0, "R5 wired=20");
    do_req(31, 0, "R5 wired=31");
    do_req(2, 0, "R5 sequence advanced through clamp");
  endtask

  task automatic t_busy_ignore();
    int extra;
    do_req(3, 1, "R7 pulses while busy");
    extra = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (valid_o) extra++;
    end
    chk(extra == 0, "R7 no extra valid", extra, 0);
    do_req(3, 0, "R7 sequence not advanced by ignored req");
  endtask

  task automatic t_wired_change();
    do_req(3, 2, "R8 wired moved during fold");
    do_req(7, 2, "R8 wired moved during fold");
  endtask

  task automatic t_held_req();
    int cnt;
    int pos0;
    int pos1;
    int e0;
    int e1;
    cnt = 0; pos0 = -1; pos1 = -1;
    @(negedge clk);
    req_i   = 1'b1;
    wired_i = WW'(4);
    @(posedge clk);
    m_seed = model_next(m_seed);
    e0 = model_idx(m_seed, 4);
    e1 = model_idx(model_next(m_seed), 4);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (n == 17) req_i = 1'b0;
      if (valid_o) begin
        if (cnt == 0) begin
          pos0 = n;
          chk(int'(idx_o) == e0, "R9 first held index", int'(idx_o), e0);
        end else begin
          pos1 = n;
          chk(int'(idx_o) == e1, "R9 second held index", int'(idx_o), e1);
        end
        cnt++;
      end
    end
    m_seed = model_next(m_seed);
    req_i = 1'b0;
    chk(cnt == 2, "R9 two results from held req", cnt, 2);
    chk(pos0 == FOLD_LAT, "R9 first position", pos0, FOLD_LAT);
    chk(pos1 == 2 * FOLD_LAT + 1, "R9 second position", pos1, 2 * FOLD_LAT + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_seq_full();
    t_wired();
    t_clamp();
    t_busy_ignore();
    t_wired_change();
    t_held_req();
    do_req(0, 0, "R2 R3 after held sequence");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule